// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides whether a received Ethernet frame passes a hash-based destination address filter. Two equal banks of table registers are held: one for unicast (individual) addresses and one for multicast (group) addresses. Software fills them word by word through a plain write port and can read any word back. For each lookup, the 48-bit destination address is run through a CRC-32. The top bits of the CRC pick a slot, and the slot selects one bit in one table register. The group bit of the address decides which bank is consulted, and the selected bit becomes the accept decision.

A single parameter picks between two variants, which fixes the slot count and the register width together. The small variant has 64 slots in 16-bit registers. The large variant has 256 slots in 32-bit registers. The MAC places a destination address on the lookup port with a one-cycle strobe and samples the registered result on the next cycle.

Top module: `hash_addr_filter`

## Requirements
- R1: With VARIANT = 0 there are 64 slots in 16-bit registers and 4 registers per bank. With VARIANT = 1 there are 256 slots in 32-bit registers and 8 registers per bank.
- R2: With N registers per bank, word addresses 0 to N-1 hold the individual bank and N to 2N-1 hold the group bank. A write replaces the whole word. Reads through rd_addr_i are combinational. A write to an address of 2N or above changes nothing, and a read there returns zero.
- R3: After reset every table word reads zero, and no lookup reports a hit.
- R4: The hash is a CRC-32 with reflected polynomial 0xEDB88320 and initial value 0xFFFFFFFF, with no final inversion. The bytes are taken in the order dst_addr_i[47:40] first and dst_addr_i[7:0] last, and each byte is fed least significant bit first.
- R5: The slot equals (slots - 1) minus the CRC's top S bits (CRC[31:32-S]), where S is 6 or 8 depending on the variant.
- R6: The register index within the bank is the slot shifted right by log2(width). The bit is bit (width - 1 - (slot mod width)), so slot 0 of each register is its most significant bit.
- R7: When dst_addr_i[40] is 1 (the group bit of the first byte), the lookup uses the group bank. Otherwise it uses the individual bank.
- R8: hit_valid_o is high exactly one cycle after lookup_valid_i. hit_o then gives the selected table bit, and hit_o is low in every other cycle.
- R9: A table write in the same cycle as a lookup is not seen by that lookup. It is seen by the next lookup.
- R10: In the 16-bit variant, read data bits 31:16 are always zero, whatever was written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table word write strobe |
| wr_addr_i | input | 4 | Table word address for writes |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Table word address for reads |
| rd_data_o | output | 32 | Read data, zero-extended |
| lookup_valid_i | input | 1 | Lookup strobe |
| dst_addr_i | input | 48 | Destination address, first wire byte in bits 47:40 |
| hit_valid_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | Address accepted by the hash table |

## Verification
The bench sets every single table bit in turn and checks lookups against an arithmetic model. This catches a design that skips the slot reversal, numbers the bits from the least significant end, or swaps the banks, because such a design would report hits in the wrong slots. A random full-table pattern is then probed with several hundred addresses of both kinds, which exposes CRC byte-order or bit-order errors as a flood of mismatches. The remaining checks cover the edges: a write that lands in the same cycle as a lookup must not change that result, because a design with a write bypass would hit early; upper bits written in the 16-bit variant must read back as zero; and out-of-range writes must leave the table unchanged.

// File: rtl/hash_filter_pkg.sv
package hash_filter_pkg;
  localparam int unsigned MAC_W    = 48;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned MAX_REGS = 8;
  localparam int unsigned ADDR_W   = $clog2(2 * MAX_REGS);
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
endpackage

// File: rtl/hash_crc48.sv
module hash_crc48 import hash_filter_pkg::*; #(
  parameter int unsigned OUT_W = 6
) (
  input  logic [MAC_W-1:0] mac_i,
  output logic [OUT_W-1:0] top_o
);
  localparam int unsigned NBYTES = MAC_W / 8;
  logic [31:0] c;

  always_comb begin
    c = CRC_INIT;
    for (int b = 0; b < NBYTES; b++) begin
      c = c ^ {24'h0, mac_i[MAC_W-1-8*b -: 8]};
      for (int k = 0; k < 8; k++) begin
        c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
      end
    end
  end

  assign top_o = c[31 -: OUT_W];
endmodule

// File: rtl/hash_slot_map.sv
module hash_slot_map #(
  parameter int unsigned SLOT_SHIFT  = 6,
  parameter int unsigned WIDTH_SHIFT = 4,
  localparam int unsigned W     = 1 << WIDTH_SHIFT,
  localparam int unsigned REG_W = SLOT_SHIFT - WIDTH_SHIFT
) (
  input  logic [SLOT_SHIFT-1:0] crc_top_i,
  output logic [REG_W-1:0]      reg_idx_o,
  output logic [W-1:0]          mask_o
);
  localparam logic [SLOT_SHIFT-1:0] SLOT_MAX = '1;
  localparam logic [W-1:0]          TOP_BIT  = W'(1) << (W - 1);

  logic [SLOT_SHIFT-1:0] slot;

  assign slot      = SLOT_MAX - crc_top_i;
  assign reg_idx_o = slot[SLOT_SHIFT-1:WIDTH_SHIFT];
  assign mask_o    = TOP_BIT >> slot[WIDTH_SHIFT-1:0];
endmodule

// File: rtl/hash_table_bank.sv
module hash_table_bank #(
  parameter int unsigned NREGS = 4,
  parameter int unsigned W     = 16,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          waddr_i,
  input  logic [W-1:0]              wdata_i,
  output logic [NREGS-1:0][W-1:0]   regs_o
);
  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_o[r] <= '0;
      else if (we_i && (waddr_i == IDX_W'(r)))   regs_o[r] <= wdata_i;
    end
  end
endmodule

// File: rtl/hash_addr_filter.sv
module hash_addr_filter import hash_filter_pkg::*; #(
  parameter int unsigned VARIANT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              lookup_valid_i,
  input  logic [MAC_W-1:0]  dst_addr_i,
  output logic              hit_valid_o,
  output logic              hit_o
);
  localparam int unsigned SLOT_SHIFT  = (VARIANT != 0) ? 8 : 6;
  localparam int unsigned WIDTH_SHIFT = (VARIANT != 0) ? 5 : 4;
  localparam int unsigned W           = 1 << WIDTH_SHIFT;
  localparam int unsigned REG_W       = SLOT_SHIFT - WIDTH_SHIFT;
  localparam int unsigned NREGS       = 1 << REG_W;
  localparam int unsigned GROUP_BIT   = MAC_W - 8;

  logic [1:0][NREGS-1:0][W-1:0] tbl;

  // write decode: bit REG_W picks the bank, higher bits must be zero
  logic wr_in_range;
  assign wr_in_range = (wr_addr_i >> (REG_W + 1)) == '0;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    hash_table_bank #(.NREGS(NREGS), .W(W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && wr_in_range && (wr_addr_i[REG_W] == 1'(g))),
      .waddr_i (wr_addr_i[REG_W-1:0]),
      .wdata_i (wr_data_i[W-1:0]),
      .regs_o  (tbl[g])
    );
  end

  logic         rd_in_range;
  logic [W-1:0] rd_word;
  assign rd_in_range = (rd_addr_i >> (REG_W + 1)) == '0;
  assign rd_word     = tbl[rd_addr_i[REG_W]][rd_addr_i[REG_W-1:0]];
  assign rd_data_o   = rd_in_range ? DATA_W'(rd_word) : '0;

  logic [SLOT_SHIFT-1:0] crc_top;
  logic [REG_W-1:0]      reg_idx;
  logic [W-1:0]          mask;
  logic                  hit_d;

  hash_crc48 #(.OUT_W(SLOT_SHIFT)) u_crc (
    .mac_i (dst_addr_i),
    .top_o (crc_top)
  );

  hash_slot_map #(.SLOT_SHIFT(SLOT_SHIFT), .WIDTH_SHIFT(WIDTH_SHIFT)) u_map (
    .crc_top_i (crc_top),
    .reg_idx_o (reg_idx),
    .mask_o    (mask)
  );

  assign hit_d = |(tbl[dst_addr_i[GROUP_BIT]][reg_idx] & mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_valid_o <= 1'b0;
      hit_o       <= 1'b0;
    end else begin
      hit_valid_o <= lookup_valid_i;
      hit_o       <= lookup_valid_i && hit_d;
    end
  end
endmodule

module hash_addr_filter_chk import hash_filter_pkg::*; #(
  parameter int unsigned VARIANT = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              lookup_valid_i,
  input logic              hit_valid_o,
  input logic              hit_o
);
  localparam int unsigned       NWORDS = (VARIANT != 0) ? 16 : 8;
  localparam logic [DATA_W-1:0] DMASK  = (VARIANT != 0) ? 32'hFFFF_FFFF : 32'h0000_FFFF;

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> hit_valid_o); // R8
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> !hit_valid_o); // R8
  AST_HIT_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> hit_valid_o); // R8
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (32'(wr_addr_i) < NWORDS)) |=>
      ((rd_addr_i != $past(wr_addr_i)) || (rd_data_o == ($past(wr_data_i) & DMASK)))); // R2
  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (!$stable(rd_addr_i) || $stable(rd_data_o))); // R2
  AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(rd_addr_i) >= NWORDS) |-> (rd_data_o == '0)); // R2

  if (VARIANT == 0) begin : g_narrow
    AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_o[31:16] == 16'h0); // R10
  end
endmodule

bind hash_addr_filter hash_addr_filter_chk #(.VARIANT(VARIANT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .wr_addr_i      (wr_addr_i),
  .wr_data_i      (wr_data_i),
  .rd_addr_i      (rd_addr_i),
  .rd_data_o      (rd_data_o),
  .lookup_valid_i (lookup_valid_i),
  .hit_valid_o    (hit_valid_o),
  .hit_o          (hit_o)
);

// File: tb/hash_addr_filter_tb.sv
module hash_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        lk_valid = 1'b0;
  logic [47:0] dst = '0;
  logic        hit_valid;
  logic        hit;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] mdl [8];
  logic [63:0] seed = 64'h1234_5678_9ABC_DEF0;

  always #10 clk = ~clk;

  hash_addr_filter #(.VARIANT(0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .lookup_valid_i(lk_valid), .dst_addr_i(dst), .hit_valid_o(hit_valid), .hit_o(hit)
  );

  // R4: reference CRC
  function automatic logic [31:0] m_crc(input logic [47:0] mac);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      c ^= {24'h0, mac[47-8*b -: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c;
  endfunction

  // R5, R6, R7: expected table bit
  function automatic logic m_hit(input logic [47:0] mac);
    int slot = 63 - int'(m_crc(mac) >> 26);
    int bank = int'(mac[40]);
    return mdl[bank*4 + slot/16][15 - (slot % 16)];
  endfunction

  function automatic logic [47:0] next_mac();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed[63:16];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 8) mdl[a] = d[15:0];
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_addr = 4'(a);
    #1;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic look(input logic [47:0] mac, input string req);
    logic e;
    @(negedge clk);
    e = m_hit(mac);
    lk_valid = 1'b1; dst = mac;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(hit_valid == 1'b1 && hit == e, req, {30'h0, hit_valid, hit}, {30'h0, 1'b1, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3: reset state
    for (int a = 0; a < 8; a++) rd_chk(a, 32'h0, "R3 reset read");
    @(negedge clk);
    chk(hit_valid == 1'b0 && hit == 1'b0, "R8 idle", {30'h0, hit_valid, hit}, 32'h0);
    for (int i = 0; i < 8; i++) look(next_mac(), "R3 no hit after reset");

    // R1, R2, R10: readback of every word, upper bits dropped
    for (int a = 0; a < 8; a++) wr(a, 32'hFFFF_0000 | 32'(16'hA5C0 + a));
    for (int a = 0; a < 8; a++) rd_chk(a, 32'(16'hA5C0 + a), "R10 R2 readback");

    // R2: out-of-range writes ignored, reads return zero
    for (int a = 8; a < 16; a++) begin
      @(negedge clk); wr_en = 1'b1; wr_addr = 4'(a); wr_data = 32'h0000_FFFF;
      @(negedge clk); wr_en = 1'b0;
    end
    for (int a = 0; a < 8; a++) rd_chk(a, 32'(16'hA5C0 + a), "R2 oor write ignored");
    for (int a = 8; a < 16; a++) rd_chk(a, 32'h0, "R2 oor read zero");

    // R5, R6, R7: single-bit sweep over both banks
    for (int a = 0; a < 8; a++) wr(a, 32'h0);
    for (int r = 0; r < 8; r++) begin
      for (int b = 0; b < 16; b++) begin
        wr(r, 32'h1 << b);
        for (int i = 0; i < 12; i++) begin
          logic [47:0] m = next_mac();
          if (i % 2 == 0) m[40] = (r >= 4);
          look(m, "R5 R6 R7 single bit sweep");
        end
      end
      wr(r, 32'h0);
    end

    // R4, R7: dense random table
    for (int a = 0; a < 8; a++) wr(a, next_mac()[31:0]);
    for (int i = 0; i < 400; i++) look(next_mac(), "R4 R7 random table");

    // R9: write colliding with a lookup of the same bit
    for (int a = 0; a < 8; a++) wr(a, 32'h0);
    begin
      logic [47:0] m = next_mac();
      int slot = 63 - int'(m_crc(m) >> 26);
      int a = int'(m[40]) * 4 + slot / 16;
      @(negedge clk);
      lk_valid = 1'b1; dst = m;
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 32'h1 << (15 - slot % 16);
      @(negedge clk);
      lk_valid = 1'b0; wr_en = 1'b0;
      mdl[a] = wr_data[15:0];
      chk(hit_valid == 1'b1 && hit == 1'b0, "R9 same-cycle write unseen", {30'h0, hit_valid, hit}, 32'h2);
      look(m, "R9 write seen next lookup");
      chk(m_hit(m) == 1'b1, "R9 model hit", 32'(m_hit(m)), 32'h1);
    end

    @(negedge clk);
    chk(hit_valid == 1'b0 && hit == 1'b0, "R8 idle after lookups", {30'h0, hit_valid, hit}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule